// File: doc/BRIEF.md
# Peripheral Transfer Pointer and Counter Engine

This block moves data between a memory-side bus and the data registers of a serial peripheral, without software polling the peripheral's ready flags. There are two independent directions. The receive direction takes each word the peripheral reports as available and writes it to memory. The transmit direction reads words from memory into a one-entry holding register, and the peripheral drains that register. Each direction has its own address pointer and its own transfer counter. Software loads these and then watches only the end-of-buffer and buffer-status flags.

Each transfer adds a stride to the pointer. The stride is 1, 2 or 4 bytes and depends on the configured data width (8 to 16 bits) and on whether packed or word-per-transfer layout is selected. The counter always drops by exactly one per transfer, whatever the stride. Bits above the configured width are forced to zero. In word-per-transfer mode, the upper half of each transmit word carries per-transfer control bits, and these go to the peripheral unchanged.

Top module: `pdma_engine`

## Requirements
- R1: While reset is asserted, and for two cycles after it is released, both pointers and counters are zero. Both request outputs and `per_tx_valid` are low, and all four status flags are high.
- R2: In packed mode with an effective width of 8, each transfer adds 1 to the pointer and subtracts 1 from the counter. The bus size code is 0 (byte). Data bits 31:8 are zero.
- R3: In packed mode with an effective width from 9 to 16, each transfer adds 2 to the pointer and subtracts 1 from the counter. The size code is 1 (halfword). Only the low `width` bits of the data survive, and all higher bits are zero.
- R4: In word mode (`cfg_var_mode`=1), each transfer adds 4 to the pointer and subtracts 1 from the counter, for any width. The size code is 2 (word). A receive word carries the masked data in its low bits and zeros above.
- R5: In word mode, bits 31:16 of a word read for transmission reach `per_tx_data` unchanged. Bits 15:0 are masked to the effective width.
- R6: A `cfg_width` below 8 acts as 8, and a value above 16 acts as 16.
- R7: No request is issued in a direction whose counter is zero. `rx_end` and `rx_full` are high exactly when the receive counter is zero. `tx_end` and `tx_empty` are high exactly when the transmit counter is zero.
- R8: A load pulse sets the pointer and the counter from the load inputs at the next edge, and suppresses that direction's request in the load cycle. A nonzero count re-arms the direction and clears its flags. A zero count leaves the flags set.
- R9: The receive request is high whenever `per_rx_valid` is high and the direction is armed. `per_rx_ready` equals request AND acknowledge. The pointer and counter advance only on an acknowledged request.
- R10: A transmit fetch is requested when the direction is armed and the holding register is empty or being drained in the same cycle. An acknowledged fetch fills the register and decrements the counter. A held word stays valid and stable until `per_tx_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_var_mode | input | 1 | 1 = word per transfer, 0 = packed |
| cfg_width | input | 5 | Data width in bits (8..16 effective) |
| rx_ld_en | input | 1 | Load receive pointer and counter |
| rx_ld_addr | input | 32 | Receive start address |
| rx_ld_cnt | input | 16 | Receive transfer count |
| tx_ld_en | input | 1 | Load transmit pointer and counter |
| tx_ld_addr | input | 32 | Transmit start address |
| tx_ld_cnt | input | 16 | Transmit transfer count |
| per_rx_valid | input | 1 | Peripheral has received data |
| per_rx_data | input | 16 | Received data |
| per_rx_ready | output | 1 | Received data taken |
| per_tx_ready | input | 1 | Peripheral transmit register empty |
| per_tx_valid | output | 1 | Holding register full |
| per_tx_data | output | 32 | Word offered to the peripheral |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_size | output | 2 | Write size code |
| mem_wr_wdata | output | 32 | Write data, LSB aligned |
| mem_wr_ack | input | 1 | Write accepted this cycle |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_size | output | 2 | Read size code |
| mem_rd_rdata | input | 32 | Read data, valid with ack |
| mem_rd_ack | input | 1 | Read completed this cycle |
| rx_end | output | 1 | Receive counter is zero |
| rx_full | output | 1 | Receive buffer full |
| tx_end | output | 1 | Transmit counter is zero |
| tx_empty | output | 1 | Transmit buffer empty |

## Verification
The checker examines every cycle for four properties. No request may be issued from a zero counter. Each acknowledged receive must add the mode-dependent stride to the pointer and take exactly one from the counter. A load must overwrite the counter and block that cycle's request. A held transmit word must stay put while the peripheral is not ready. Packed byte writes must also carry zero upper bits. Several behaviours only show up when the bench's reference model follows traffic through many cycles and compares it. These are width clamping, masking at each width, pass-through of the transmit control half in word mode, a reload landing in the middle of a running buffer, and refill of the holding register in the same cycle it drains.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2
  } xfer_size_e;

  localparam int STRIDE_W = 3;
endpackage

// File: rtl/pdma_fmt.sv
module pdma_fmt
  import pdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MIN_W  = 8,
  parameter int WID_W  = 5
) (
  input  logic                cfg_var_mode,
  input  logic [WID_W-1:0]    cfg_width,
  output logic [STRIDE_W-1:0] stride,
  output xfer_size_e          size,
  output logic [DATA_W-1:0]   mask
);
  logic [WID_W-1:0] eff_w;

  always_comb begin
    if (cfg_width < WID_W'(MIN_W)) begin
      eff_w = WID_W'(MIN_W);
    end else if (cfg_width > WID_W'(DATA_W)) begin
      eff_w = WID_W'(DATA_W);
    end else begin
      eff_w = cfg_width;
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (i < int'(eff_w));
    end
  end

  always_comb begin
    if (cfg_var_mode) begin
      stride = STRIDE_W'(4);
      size   = XS_WORD;
    end else if (eff_w == WID_W'(MIN_W)) begin
      stride = STRIDE_W'(1);
      size   = XS_BYTE;
    end else begin
      stride = STRIDE_W'(2);
      size   = XS_HALF;
    end
  end
endmodule

// File: rtl/pdma_ptrcnt.sv
module pdma_ptrcnt
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [ADDR_W-1:0]   ld_addr,
  input  logic [CNT_W-1:0]    ld_cnt,
  input  logic                step_en,
  input  logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0]   ptr,
  output logic [CNT_W-1:0]    cnt
);
  logic [ADDR_W-1:0] ptr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              upd_en;

  always_comb begin
    ptr_d  = ptr;
    cnt_d  = cnt;
    upd_en = 1'b0;
    if (ld_en) begin
      ptr_d  = ld_addr;
      cnt_d  = ld_cnt;
      upd_en = 1'b1;
    end else if (step_en && (cnt != '0)) begin
      ptr_d  = ptr + ADDR_W'(stride);
      cnt_d  = cnt - CNT_W'(1);
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (upd_en) begin
      ptr <= ptr_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/pdma_txhold.sv
module pdma_txhold #(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              var_mode,
  input  logic [DATA_W-1:0] mask,
  input  logic              fill,
  input  logic [BUS_W-1:0]  fill_raw,
  input  logic              drain,
  output logic              valid,
  output logic [BUS_W-1:0]  data
);
  localparam int UP_W = BUS_W - DATA_W;

  logic [BUS_W-1:0] fmt_word;
  logic             valid_d;
  logic [BUS_W-1:0] data_d;

  always_comb begin
    if (var_mode) begin
      fmt_word = {fill_raw[BUS_W-1:DATA_W], fill_raw[DATA_W-1:0] & mask};
    end else begin
      fmt_word = {{UP_W{1'b0}}, fill_raw[DATA_W-1:0] & mask};
    end
  end

  always_comb begin
    valid_d = valid;
    data_d  = data;
    if (fill) begin
      valid_d = 1'b1;
      data_d  = fmt_word;
    end else if (drain) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= valid_d;
      if (fill) begin
        data <= data_d;
      end
    end
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32,
  parameter int WID_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_var_mode,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              rx_ld_en,
  input  logic [ADDR_W-1:0] rx_ld_addr,
  input  logic [CNT_W-1:0]  rx_ld_cnt,
  input  logic              tx_ld_en,
  input  logic [ADDR_W-1:0] tx_ld_addr,
  input  logic [CNT_W-1:0]  tx_ld_cnt,
  input  logic              per_rx_valid,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              per_rx_ready,
  input  logic              per_tx_ready,
  output logic              per_tx_valid,
  output logic [BUS_W-1:0]  per_tx_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [1:0]        mem_wr_size,
  output logic [BUS_W-1:0]  mem_wr_wdata,
  input  logic              mem_wr_ack,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [1:0]        mem_rd_size,
  input  logic [BUS_W-1:0]  mem_rd_rdata,
  input  logic              mem_rd_ack,
  output logic              rx_end,
  output logic              rx_full,
  output logic              tx_end,
  output logic              tx_empty
);
  localparam int NCH  = 2;
  localparam int CH_RX = 0;
  localparam int CH_TX = 1;
  localparam int UP_W = BUS_W - DATA_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [STRIDE_W-1:0] stride;
  xfer_size_e          xsize;
  logic [DATA_W-1:0]   mask;

  pdma_fmt #(.DATA_W(DATA_W), .MIN_W(8), .WID_W(WID_W)) u_fmt (
    .cfg_var_mode (cfg_var_mode),
    .cfg_width    (cfg_width),
    .stride       (stride),
    .size         (xsize),
    .mask         (mask)
  );

  logic              ld_en_a   [NCH];
  logic [ADDR_W-1:0] ld_addr_a [NCH];
  logic [CNT_W-1:0]  ld_cnt_a  [NCH];
  logic              step_a    [NCH];
  logic [ADDR_W-1:0] ptr_a     [NCH];
  logic [CNT_W-1:0]  cnt_a     [NCH];

  assign ld_en_a[CH_RX]   = rx_ld_en;
  assign ld_addr_a[CH_RX] = rx_ld_addr;
  assign ld_cnt_a[CH_RX]  = rx_ld_cnt;
  assign ld_en_a[CH_TX]   = tx_ld_en;
  assign ld_addr_a[CH_TX] = tx_ld_addr;
  assign ld_cnt_a[CH_TX]  = tx_ld_cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pdma_ptrcnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pc (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ld_en   (ld_en_a[g]),
      .ld_addr (ld_addr_a[g]),
      .ld_cnt  (ld_cnt_a[g]),
      .step_en (step_a[g]),
      .stride  (stride),
      .ptr     (ptr_a[g]),
      .cnt     (cnt_a[g])
    );
  end

  logic [ADDR_W-1:0] rx_ptr, tx_ptr;
  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  assign rx_ptr = ptr_a[CH_RX];
  assign tx_ptr = ptr_a[CH_TX];
  assign rx_cnt = cnt_a[CH_RX];
  assign tx_cnt = cnt_a[CH_TX];

  logic rx_armed, tx_armed;
  assign rx_armed = (rx_cnt != '0);
  assign tx_armed = (tx_cnt != '0);

  // receive side: peripheral word straight onto the write bus
  assign mem_wr_req   = per_rx_valid & rx_armed & ~rx_ld_en;
  assign mem_wr_addr  = rx_ptr;
  assign mem_wr_size  = xsize;
  assign mem_wr_wdata = {{UP_W{1'b0}}, per_rx_data & mask};
  assign per_rx_ready = mem_wr_req & mem_wr_ack;
  assign step_a[CH_RX] = per_rx_ready;

  // transmit side: fetch into a one-entry holding register
  logic hold_valid, hold_drain, hold_fill;
  assign hold_drain   = hold_valid & per_tx_ready;
  assign mem_rd_req   = tx_armed & ~tx_ld_en & (~hold_valid | per_tx_ready);
  assign mem_rd_addr  = tx_ptr;
  assign mem_rd_size  = xsize;
  assign hold_fill    = mem_rd_req & mem_rd_ack;
  assign step_a[CH_TX] = hold_fill;

  pdma_txhold #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .var_mode (cfg_var_mode),
    .mask     (mask),
    .fill     (hold_fill),
    .fill_raw (mem_rd_rdata),
    .drain    (hold_drain),
    .valid    (hold_valid),
    .data     (per_tx_data)
  );
  assign per_tx_valid = hold_valid;

  assign rx_end   = ~rx_armed;
  assign rx_full  = ~rx_armed;
  assign tx_end   = ~tx_armed;
  assign tx_empty = ~tx_armed;
endmodule

// File: rtl/pdma_engine_chk.sv
module pdma_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BUS_W  = 32,
  parameter int WID_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_var_mode,
  input logic [WID_W-1:0]  cfg_width,
  input logic              rx_ld_en,
  input logic [CNT_W-1:0]  rx_ld_cnt,
  input logic              mem_wr_req,
  input logic              mem_wr_ack,
  input logic [BUS_W-1:0]  mem_wr_wdata,
  input logic              mem_rd_req,
  input logic              per_tx_valid,
  input logic              per_tx_ready,
  input logic [BUS_W-1:0]  per_tx_data,
  input logic              rx_end,
  input logic              tx_end,
  input logic [ADDR_W-1:0] rx_ptr,
  input logic [CNT_W-1:0]  rx_cnt
);
  logic [ADDR_W-1:0] exp_stride;
  assign exp_stride = cfg_var_mode ? ADDR_W'(4)
                    : (cfg_width <= WID_W'(8)) ? ADDR_W'(1) : ADDR_W'(2);

  // R7
  rx_req_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !rx_end);

  // R7
  tx_req_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !tx_end);

  // R9
  rx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> (rx_cnt == $past(rx_cnt) - CNT_W'(1)));

  // R4
  rx_ptr_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> (rx_ptr == $past(rx_ptr) + $past(exp_stride)));

  // R8
  rx_load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ld_en |=> (rx_cnt == $past(rx_ld_cnt)));

  // R8
  rx_load_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ld_en |-> !mem_wr_req);

  // R2
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !cfg_var_mode && (exp_stride == ADDR_W'(1))) |-> (mem_wr_wdata[BUS_W-1:8] == '0));

  // R10
  tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tx_valid && !per_tx_ready) |=> (per_tx_valid && $stable(per_tx_data)));
endmodule

bind pdma_engine pdma_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_W(BUS_W), .WID_W(WID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cfg_var_mode (cfg_var_mode),
  .cfg_width    (cfg_width),
  .rx_ld_en     (rx_ld_en),
  .rx_ld_cnt    (rx_ld_cnt),
  .mem_wr_req   (mem_wr_req),
  .mem_wr_ack   (mem_wr_ack),
  .mem_wr_wdata (mem_wr_wdata),
  .mem_rd_req   (mem_rd_req),
  .per_tx_valid (per_tx_valid),
  .per_tx_ready (per_tx_ready),
  .per_tx_data  (per_tx_data),
  .rx_end       (rx_end),
  .tx_end       (tx_end),
  .rx_ptr       (rx_ptr),
  .rx_cnt       (rx_cnt)
);

// File: tb/pdma_engine_test.sv
module pdma_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        cfg_var_mode;
  logic [4:0]  cfg_width;
  logic        rx_ld_en, tx_ld_en;
  logic [31:0] rx_ld_addr, tx_ld_addr;
  logic [15:0] rx_ld_cnt, tx_ld_cnt;
  logic        per_rx_valid, per_rx_ready, per_tx_ready, per_tx_valid;
  logic [15:0] per_rx_data;
  logic [31:0] per_tx_data;
  logic        mem_wr_req, mem_wr_ack, mem_rd_req, mem_rd_ack;
  logic [31:0] mem_wr_addr, mem_wr_wdata, mem_rd_addr, mem_rd_rdata;
  logic [1:0]  mem_wr_size, mem_rd_size;
  logic        rx_end, rx_full, tx_end, tx_empty;
  logic        wack_en, rack_en;

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] ^ 16'h0F96};
  endfunction

  assign mem_wr_ack   = mem_wr_req & wack_en;
  assign mem_rd_ack   = mem_rd_req & rack_en;
  assign mem_rd_rdata = rd_pat(mem_rd_addr);

  pdma_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_var_mode(cfg_var_mode), .cfg_width(cfg_width),
    .rx_ld_en(rx_ld_en), .rx_ld_addr(rx_ld_addr), .rx_ld_cnt(rx_ld_cnt),
    .tx_ld_en(tx_ld_en), .tx_ld_addr(tx_ld_addr), .tx_ld_cnt(tx_ld_cnt),
    .per_rx_valid(per_rx_valid), .per_rx_data(per_rx_data), .per_rx_ready(per_rx_ready),
    .per_tx_ready(per_tx_ready), .per_tx_valid(per_tx_valid), .per_tx_data(per_tx_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_size(mem_wr_size),
    .mem_wr_wdata(mem_wr_wdata), .mem_wr_ack(mem_wr_ack),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_size(mem_rd_size),
    .mem_rd_rdata(mem_rd_rdata), .mem_rd_ack(mem_rd_ack),
    .rx_end(rx_end), .rx_full(rx_full), .tx_end(tx_end), .tx_empty(tx_empty)
  );

  int n_chk = 0;
  int n_err = 0;
  bit in_reset = 1'b1;

  // behavioural reference state
  bit [31:0] m_ptr [2] = '{32'h0, 32'h0};
  int        m_cnt [2] = '{0, 0};
  bit        m_hv = 1'b0;
  bit [31:0] m_hd = 32'h0;
  string     m_htag = "R10";

  bit [31:0] e_mask;
  int        e_stride, e_size;
  bit        e_wreq, e_rreq;

  function automatic int eff_w();
    int w = int'(cfg_width);
    if (w < 8) return 8;
    if (w > 16) return 16;
    return w;
  endfunction

  function automatic string mtag();
    if (cfg_var_mode) return "R4";
    if (int'(cfg_width) < 8 || int'(cfg_width) > 16) return "R6";
    if (eff_w() == 8) return "R2";
    return "R3";
  endfunction

  task automatic calc();
    e_mask   = (32'h1 << eff_w()) - 32'h1;
    e_stride = cfg_var_mode ? 4 : (eff_w() == 8 ? 1 : 2);
    e_size   = cfg_var_mode ? 2 : (eff_w() == 8 ? 0 : 1);
    e_wreq   = per_rx_valid && (m_cnt[0] != 0) && !rx_ld_en;
    e_rreq   = (m_cnt[1] != 0) && !tx_ld_en && (!m_hv || per_tx_ready);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against the model once per cycle, away from the active edge
  always @(negedge clk) begin
    string t;
    calc();
    t = in_reset ? "R1" : (rx_ld_en ? "R8" : "R9");
    chk(mem_wr_req === e_wreq, t, "mem_wr_req", 32'(mem_wr_req), 32'(e_wreq));
    chk(per_rx_ready === (e_wreq && wack_en), in_reset ? "R1" : "R9", "per_rx_ready",
        32'(per_rx_ready), 32'(e_wreq && wack_en));
    if (e_wreq) begin
      chk(mem_wr_addr === m_ptr[0], mtag(), "mem_wr_addr", mem_wr_addr, m_ptr[0]);
      chk(mem_wr_size === 2'(e_size), mtag(), "mem_wr_size", 32'(mem_wr_size), 32'(e_size));
      chk(mem_wr_wdata === (32'(per_rx_data) & e_mask), mtag(), "mem_wr_wdata",
          mem_wr_wdata, 32'(per_rx_data) & e_mask);
    end
    t = in_reset ? "R1" : (tx_ld_en ? "R8" : "R10");
    chk(mem_rd_req === e_rreq, t, "mem_rd_req", 32'(mem_rd_req), 32'(e_rreq));
    if (e_rreq) begin
      chk(mem_rd_addr === m_ptr[1], mtag(), "mem_rd_addr", mem_rd_addr, m_ptr[1]);
      chk(mem_rd_size === 2'(e_size), mtag(), "mem_rd_size", 32'(mem_rd_size), 32'(e_size));
    end
    chk(per_tx_valid === m_hv, in_reset ? "R1" : "R10", "per_tx_valid",
        32'(per_tx_valid), 32'(m_hv));
    if (m_hv) chk(per_tx_data === m_hd, m_htag, "per_tx_data", per_tx_data, m_hd);
    t = in_reset ? "R1" : "R7";
    chk(rx_end === (m_cnt[0] == 0), t, "rx_end", 32'(rx_end), 32'(m_cnt[0] == 0));
    chk(rx_full === (m_cnt[0] == 0), t, "rx_full", 32'(rx_full), 32'(m_cnt[0] == 0));
    chk(tx_end === (m_cnt[1] == 0), t, "tx_end", 32'(tx_end), 32'(m_cnt[1] == 0));
    chk(tx_empty === (m_cnt[1] == 0), t, "tx_empty", 32'(tx_empty), 32'(m_cnt[1] == 0));
  end

  // advance the model on the active edge
  always @(posedge clk) begin
    bit [31:0] raw;
    calc();
    if (!rst_n) begin
      m_ptr[0] = 0; m_ptr[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0; m_hv = 0;
    end else begin
      if (rx_ld_en) begin
        m_ptr[0] = rx_ld_addr; m_cnt[0] = int'(rx_ld_cnt);
      end else if (e_wreq && wack_en) begin
        m_ptr[0] = m_ptr[0] + 32'(e_stride); m_cnt[0]--;
      end
      if (e_rreq && rack_en) begin
        raw    = rd_pat(m_ptr[1]);
        m_hd   = cfg_var_mode ? {raw[31:16], raw[15:0] & e_mask[15:0]}
                              : {16'h0, raw[15:0] & e_mask[15:0]};
        m_htag = cfg_var_mode ? "R5" : mtag();
        m_hv   = 1'b1;
      end else if (m_hv && per_tx_ready) begin
        m_hv = 1'b0;
      end
      if (tx_ld_en) begin
        m_ptr[1] = tx_ld_addr; m_cnt[1] = int'(tx_ld_cnt);
      end else if (e_rreq && rack_en) begin
        m_ptr[1] = m_ptr[1] + 32'(e_stride); m_cnt[1]--;
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;

  // mode 0: all ready, 1: pseudo-random, 2: peripheral transmit stalled
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      per_rx_data  = lfsr ^ 16'h9E37;
      per_rx_valid = (mode == 1) ? lfsr[0] : 1'b1;
      per_tx_ready = (mode == 1) ? (lfsr[3] | lfsr[5]) : (mode == 0);
      wack_en      = (mode == 1) ? (lfsr[1] | lfsr[7]) : 1'b1;
      rack_en      = (mode == 1) ? (lfsr[2] | lfsr[9]) : 1'b1;
    end
  endtask

  task automatic load(input bit do_rx, input bit do_tx, input logic [31:0] ra,
                      input logic [15:0] rc, input logic [31:0] ta, input logic [15:0] tc);
    @(posedge clk); #1;
    rx_ld_en = do_rx; rx_ld_addr = ra; rx_ld_cnt = rc;
    tx_ld_en = do_tx; tx_ld_addr = ta; tx_ld_cnt = tc;
    @(posedge clk); #1;
    rx_ld_en = 1'b0; tx_ld_en = 1'b0;
  endtask

  task automatic set_cfg(input bit v, input logic [4:0] w);
    @(posedge clk); #1;
    cfg_var_mode = v; cfg_width = w;
  endtask

  initial begin
    #(8 * 150000);
    n_err++; n_chk++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_var_mode = 1'b0; cfg_width = 5'd8;
    rx_ld_en = 0; tx_ld_en = 0; rx_ld_addr = 0; tx_ld_addr = 0; rx_ld_cnt = 0; tx_ld_cnt = 0;
    per_rx_valid = 0; per_rx_data = 0; per_tx_ready = 0; wack_en = 0; rack_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);   // R1: synchronised release, idle outputs checked throughout
    #1 in_reset = 1'b0;
    // R2: packed bytes
    load(1, 1, 32'h100, 16'd5, 32'h200, 16'd4);
    run(15, 0);
    load(1, 1, 32'h140, 16'd9, 32'h240, 16'd9);
    run(25, 1);
    // R3: packed 12-bit, then reload mid-buffer (R8)
    set_cfg(0, 5'd12);
    load(1, 1, 32'h1001, 16'd6, 32'h2001, 16'd7);
    run(6, 1);
    load(1, 0, 32'h300, 16'd3, 32'h0, 16'd0);
    run(30, 1);
    // R4/R5: word mode at 16 and 10 bits
    set_cfg(1, 5'd16);
    load(1, 1, 32'h400, 16'd8, 32'h500, 16'd8);
    run(40, 1);
    set_cfg(1, 5'd10);
    load(1, 1, 32'h600, 16'd6, 32'h700, 16'd6);
    run(30, 1);
    // R6: clamping below and above the range
    set_cfg(0, 5'd3);
    load(1, 1, 32'h800, 16'd5, 32'h900, 16'd5);
    run(20, 1);
    set_cfg(0, 5'd20);
    load(1, 1, 32'hA00, 16'd5, 32'hB00, 16'd5);
    run(20, 1);
    // R8/R7: zero count keeps flags set, no requests
    load(1, 1, 32'hC00, 16'd0, 32'hD00, 16'd0);
    run(6, 0);
    // R10: transmit stall holds the word, then drains
    set_cfg(1, 5'd13);
    load(0, 1, 32'h0, 16'd0, 32'hE00, 16'd3);
    run(8, 2);
    run(10, 0);
    run(5, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule